// File: doc/BRIEF.md
# Dual-Output Prioritised Interrupt Controller

This block collects 64 level-sensitive interrupt sources and turns them into two request lines for a processor: a normal request (`irq`) and a fast request (`fiq`). Each source has a pending bit that follows its input, an enable bit, and a type bit that steers it to the fast line (1) or the normal line (0). Each source also has a 4-bit priority, and a 5-bit mask threshold decides which normal sources may raise `irq`.

Software reaches the state through a plain 32-bit register bus. A write takes effect on the clock edge where `wr_en` is high. A read is combinational: `rdata` shows the word selected by `addr`. The word index is `addr[11:2]`. Enables can be set or cleared one source at a time by number, or written as whole 32-bit halves. The pending vector can also be overwritten from the bus to force or drop requests. Both request lines come from flops and have no handshake.

Top module: `dual_irq_ctrl`

## Requirements
- R1: A rising edge on `src_in[i]` sets pending bit i. A falling edge clears it. Word 18 reads pending bits 63:32 and word 19 reads bits 31:0.
- R2: `fiq` is high exactly when at least one source is pending, enabled and has type bit 1.
- R3: `irq` is high when a pending, enabled source of type 0 has a priority strictly above the mask. When the mask is 0x1F, any such source raises `irq` whatever its priority. A mask from 16 to 30 blocks every normal source.
- R4: Writing N to word 2 sets enable bit N, and writing N to word 3 clears it. N is taken from `wdata[5:0]`. Words 2 and 3 read as zero.
- R5: Words 4 and 5 read and write enable bits 63:32 and 31:0. Words 6 and 7 do the same for the type bits.
- R6: Words 8 to 15 each hold eight 4-bit priorities. Word 15 holds sources 0–7 and word 8 holds sources 56–63. Source 8k+j sits in bits 4j+3:4j of word 15−k.
- R7: A write to word 20 replaces pending bits 63:32, and a write to word 21 replaces bits 31:0. Both words read as zero.
- R8: Words 22/23 read pending&enable&~type and words 24/25 read pending&enable&type, each as high/low halves. Writes to words 16–19 and 22–25 change nothing.
- R9: After reset, pending, enable, type, control and all priorities are zero, the mask is 0x1F, and both request lines are low.
- R10: Word 0x40 (byte 0x100) reads the constant 4. Writes to bytes 0x100–0x2FC change nothing. Any address with no defined word reads zero.
- R11: The control word (word 0) stores only bits 0 and 2–6. Bit 1 is a sticky flag that no event in this block sets, so it reads zero, as do bits 7–31.
- R12: The request lines are registered. They reflect the state one clock after it changes, so a source edge reaches `fiq`/`irq` on the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| src_in | input | 64 | Level-sensitive interrupt sources |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |

## Verification
Some behaviours can be checked on every cycle, because each is a fixed relation between registered state and the next cycle. These are: the fast line tracking the fast-typed active set, the normal line never rising without an active normal source, a mask in the 16–30 band blocking `irq`, force and enable-by-number writes landing in the state, and the mask value right after reset. The rest can only be shown by the bench's scenarios. That covers the register map itself: the reversed priority word order, half-word placement, zero-reading command words, the constant word, the ignored range and the control bit filter. It also covers the exact threshold edge, where mask equals priority and the request falls.

// File: rtl/dic_pkg.sv
package dic_pkg;
  localparam int NUM_SRC       = 64;
  localparam int DATA_W        = 32;
  localparam int PRIO_W        = 4;
  localparam int MASK_W        = 5;
  localparam int ADDR_W        = 12;
  localparam int WORD_W        = ADDR_W - 2;
  localparam int NUM_ID_W      = $clog2(NUM_SRC);
  localparam int PRIO_PER_WORD = DATA_W / PRIO_W;
  localparam int PRIO_WORDS    = NUM_SRC / PRIO_PER_WORD;

  localparam logic [WORD_W-1:0] W_CTRL     = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_MASK     = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_EN_NUM   = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_DIS_NUM  = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_EN_HI    = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_EN_LO    = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_TYPE_HI  = WORD_W'(6);
  localparam logic [WORD_W-1:0] W_TYPE_LO  = WORD_W'(7);
  localparam logic [WORD_W-1:0] W_PRIO_END = WORD_W'(15);
  localparam logic [WORD_W-1:0] W_PEND_HI  = WORD_W'(18);
  localparam logic [WORD_W-1:0] W_PEND_LO  = WORD_W'(19);
  localparam logic [WORD_W-1:0] W_FORCE_HI = WORD_W'(20);
  localparam logic [WORD_W-1:0] W_FORCE_LO = WORD_W'(21);
  localparam logic [WORD_W-1:0] W_NORM_HI  = WORD_W'(22);
  localparam logic [WORD_W-1:0] W_NORM_LO  = WORD_W'(23);
  localparam logic [WORD_W-1:0] W_FAST_HI  = WORD_W'(24);
  localparam logic [WORD_W-1:0] W_FAST_LO  = WORD_W'(25);
  localparam logic [WORD_W-1:0] W_CONST    = WORD_W'(64);

  localparam logic [DATA_W-1:0] CONST_VAL  = DATA_W'(4);
  localparam logic [DATA_W-1:0] CTRL_KEEP  = DATA_W'(32'h7D);
  localparam logic [MASK_W-1:0] MASK_OPEN  = '1;

  typedef struct packed {
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC-1:0]        en;
    logic [NUM_SRC-1:0]        fast;
    logic [NUM_SRC*PRIO_W-1:0] prio;
    logic [MASK_W-1:0]         mask;
    logic [DATA_W-1:0]         ctrl;
  } dic_state_t;
endpackage

// File: rtl/dic_regfile.sv
module dic_regfile
  import dic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   word,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0]  src_in,
  output dic_state_t          st
);
  localparam int HALF = DATA_W;

  logic [NUM_SRC-1:0] src_q;
  logic [NUM_SRC-1:0] rise, fall;
  logic [NUM_SRC-1:0] pend_n, en_n, fast_n;
  logic [NUM_SRC*PRIO_W-1:0] prio_n;
  logic [MASK_W-1:0]  mask_n;
  logic [DATA_W-1:0]  ctrl_n;
  logic [NUM_ID_W-1:0] num;

  assign rise = src_in & ~src_q;
  assign fall = ~src_in & src_q;
  assign num  = wdata[NUM_ID_W-1:0];

  always_comb begin
    pend_n = st.pend;
    en_n   = st.en;
    fast_n = st.fast;
    prio_n = st.prio;
    mask_n = st.mask;
    ctrl_n = st.ctrl;
    if (wr_en) begin
      case (word)
        W_CTRL:     ctrl_n = wdata & CTRL_KEEP;
        W_MASK:     mask_n = wdata[MASK_W-1:0];
        W_EN_NUM:   en_n[num] = 1'b1;
        W_DIS_NUM:  en_n[num] = 1'b0;
        W_EN_HI:    en_n[NUM_SRC-1:HALF] = wdata;
        W_EN_LO:    en_n[HALF-1:0] = wdata;
        W_TYPE_HI:  fast_n[NUM_SRC-1:HALF] = wdata;
        W_TYPE_LO:  fast_n[HALF-1:0] = wdata;
        W_FORCE_HI: pend_n[NUM_SRC-1:HALF] = wdata;
        W_FORCE_LO: pend_n[HALF-1:0] = wdata;
        default: begin
          for (int w = 0; w < PRIO_WORDS; w++) begin
            if (word == W_PRIO_END - WORD_W'(w))
              prio_n[w*DATA_W +: DATA_W] = wdata;
          end
        end
      endcase
    end
    pend_n = (pend_n | rise) & ~fall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      st.pend <= '0;
      st.en   <= '0;
      st.fast <= '0;
      st.prio <= '0;
      st.mask <= MASK_OPEN;
      st.ctrl <= '0;
    end else begin
      src_q   <= src_in;
      st.pend <= pend_n;
      st.en   <= en_n;
      st.fast <= fast_n;
      st.prio <= prio_n;
      st.mask <= mask_n;
      st.ctrl <= ctrl_n;
    end
  end

  AST_MASK_AFTER_RESET: assert property (@(posedge clk)
    $rose(rst_n) |-> (st.mask == MASK_OPEN && st.en == '0 && st.pend == '0)); // R9
  AST_FORCE_LOW_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_FORCE_LO && src_in == src_q)
      |=> (st.pend[HALF-1:0] == $past(wdata))); // R7
  AST_ENABLE_BY_NUMBER: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_EN_NUM) |=> st.en[$past(num)]); // R4
endmodule

// File: rtl/dic_readmux.sv
module dic_readmux
  import dic_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  dic_state_t        st,
  output logic [DATA_W-1:0] rdata
);
  localparam int HALF = DATA_W;

  logic [NUM_SRC-1:0] norm_act, fast_act;
  assign norm_act = st.pend & st.en & ~st.fast;
  assign fast_act = st.pend & st.en & st.fast;

  always_comb begin
    rdata = '0;
    case (word)
      W_CTRL:    rdata = st.ctrl;
      W_MASK:    rdata = DATA_W'(st.mask);
      W_EN_HI:   rdata = st.en[NUM_SRC-1:HALF];
      W_EN_LO:   rdata = st.en[HALF-1:0];
      W_TYPE_HI: rdata = st.fast[NUM_SRC-1:HALF];
      W_TYPE_LO: rdata = st.fast[HALF-1:0];
      W_PEND_HI: rdata = st.pend[NUM_SRC-1:HALF];
      W_PEND_LO: rdata = st.pend[HALF-1:0];
      W_NORM_HI: rdata = norm_act[NUM_SRC-1:HALF];
      W_NORM_LO: rdata = norm_act[HALF-1:0];
      W_FAST_HI: rdata = fast_act[NUM_SRC-1:HALF];
      W_FAST_LO: rdata = fast_act[HALF-1:0];
      W_CONST:   rdata = CONST_VAL;
      default: begin
        for (int w = 0; w < PRIO_WORDS; w++) begin
          if (word == W_PRIO_END - WORD_W'(w))
            rdata = st.prio[w*DATA_W +: DATA_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/dic_reqgen.sv
module dic_reqgen
  import dic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dic_state_t st,
  output logic       irq,
  output logic       fiq
);
  logic [NUM_SRC-1:0] norm_act, fast_act, above;
  logic irq_d, fiq_d;

  assign norm_act = st.pend & st.en & ~st.fast;
  assign fast_act = st.pend & st.en & st.fast;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
    assign above[i] = norm_act[i] &&
      ({1'b0, st.prio[i*PRIO_W +: PRIO_W]} > st.mask);
  end

  assign fiq_d = |fast_act;
  assign irq_d = (|norm_act) && ((st.mask == MASK_OPEN) || (|above));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      fiq <= 1'b0;
    end else begin
      irq <= irq_d;
      fiq <= fiq_d;
    end
  end

  AST_FIQ_TRACKS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    fiq == $past(|(st.pend & st.en & st.fast))); // R2
  AST_IRQ_NEEDS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|(st.pend & st.en & ~st.fast))); // R3
  AST_MASK_BAND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st.mask) > 5'd15 && $past(st.mask) != MASK_OPEN) |-> !irq); // R3
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import dic_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq,
  output logic               fiq
);
  logic [WORD_W-1:0] word;
  dic_state_t        st;

  assign word = addr[ADDR_W-1:2];

  dic_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .word(word),
    .wdata(wdata), .src_in(src_in), .st(st)
  );

  dic_readmux u_rmux (.word(word), .st(st), .rdata(rdata));

  dic_reqgen u_req (
    .clk(clk), .rst_n(rst_n), .st(st), .irq(irq), .fiq(fiq)
  );
endmodule

// File: tb/dual_irq_ctrl_bench.sv
module dual_irq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] src_in = '0;
  logic        irq, fiq;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dual_irq_ctrl u_dual_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_in(src_in), .irq(irq), .fiq(fiq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input int wordi, input logic [31:0] d);
    @(negedge clk);
    addr = 12'(wordi * 4); wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_byte(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string tag, input int wordi, input logic [31:0] exp);
    addr = 12'(wordi * 4);
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 irq", {31'd0, irq}, 32'd0);
    chk("R9 fiq", {31'd0, fiq}, 32'd0);
    rd("R9 mask", 1, 32'h1F);
    rd("R9 enable lo", 5, 32'd0);
    rd("R9 type hi", 6, 32'd0);
    rd("R9 prio", 15, 32'd0);
    rd("R9 pending", 19, 32'd0);
    rd("R9 ctrl", 0, 32'd0);
  endtask

  task automatic t_words;
    wr(4, 32'h1234_5678); rd("R5 enable hi", 4, 32'h1234_5678);
    wr(5, 32'hCAFE_0000); rd("R5 enable lo", 5, 32'hCAFE_0000);
    rd("R5 hi kept", 4, 32'h1234_5678);
    wr(7, 32'h0000_0F0F); rd("R5 type lo", 7, 32'h0000_0F0F);
    wr(4, 0); wr(5, 0); wr(7, 0);
    rd("R5 cleared", 5, 32'd0);
  endtask

  task automatic t_enable_num;
    wr(2, 32'h47); rd("R4 enable 7 via wdata[5:0]", 5, 32'h80);
    wr(2, 37);     rd("R4 enable 37", 4, 32'h20);
    rd("R4 word2 reads zero", 2, 32'd0);
    rd("R4 word3 reads zero", 3, 32'd0);
    wr(3, 37);     rd("R4 disable 37", 4, 32'd0);
    wr(3, 7);      rd("R4 disable 7", 5, 32'd0);
  endtask

  task automatic t_prio;
    wr(15, 32'h7654_3210); wr(8, 32'hFEDC_BA98);
    rd("R6 word15", 15, 32'h7654_3210);
    rd("R6 word8", 8, 32'hFEDC_BA98);
    rd("R6 word12 untouched", 12, 32'd0);
  endtask

  task automatic t_irq;
    // source 63 has priority F (word 8 top nibble): enable, mask 14 -> request
    wr(2, 63); wr(1, 14);
    @(negedge clk); src_in[63] = 1'b1;
    wait_n(2);
    chk("R6 source63 prio F above mask 14", {31'd0, irq}, 32'd1);
    wr(1, 15); wait_n(1);
    chk("R3 mask 15 blocks prio F", {31'd0, irq}, 32'd0);
    @(negedge clk); src_in[63] = 1'b0; wait_n(2);
    wr(3, 63); wr(1, 31);
    // source 3 has priority 3
    wr(2, 3);
    @(negedge clk); src_in[3] = 1'b1;
    wait_n(1);
    rd("R1 pending set by edge", 19, 32'h8);
    chk("R12 irq still low after one edge", {31'd0, irq}, 32'd0);
    wait_n(1);
    chk("R3 mask 1F passes any", {31'd0, irq}, 32'd1);
    wr(1, 2); wait_n(1);
    chk("R3 prio 3 above mask 2", {31'd0, irq}, 32'd1);
    wr(1, 3); wait_n(1);
    chk("R3 prio equal mask blocked", {31'd0, irq}, 32'd0);
    wr(1, 20); wait_n(1);
    chk("R3 mask 20 blocks", {31'd0, irq}, 32'd0);
    wr(1, 31); wait_n(1);
    chk("R3 mask back to 1F", {31'd0, irq}, 32'd1);
    @(negedge clk); src_in[3] = 1'b0;
    wait_n(2);
    rd("R1 pending cleared by edge", 19, 32'd0);
    chk("R1 irq drops", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_fiq;
    wr(6, 32'h100); wr(2, 40);
    @(negedge clk); src_in[40] = 1'b1;
    wait_n(1);
    chk("R12 fiq low after one edge", {31'd0, fiq}, 32'd0);
    wait_n(1);
    chk("R2 fiq high", {31'd0, fiq}, 32'd1);
    chk("R2 irq stays low", {31'd0, irq}, 32'd0);
    rd("R8 fast view hi", 24, 32'h100);
    rd("R8 fast view lo", 25, 32'd0);
    rd("R8 normal view hi", 22, 32'd0);
    rd("R1 pending hi", 18, 32'h100);
    @(negedge clk); src_in[40] = 1'b0;
    wait_n(2);
    chk("R2 fiq drops", {31'd0, fiq}, 32'd0);
  endtask

  task automatic t_force;
    wr(21, 32'h9); wait_n(1);
    rd("R7 force lo", 19, 32'h9);
    rd("R7 force word reads zero", 21, 32'd0);
    rd("R8 normal view lo", 23, 32'h8);
    chk("R7 forced irq", {31'd0, irq}, 32'd1);
    wr(19, 32'd0); rd("R8 pending word read only", 19, 32'h9);
    wr(23, 32'd0); rd("R8 view word read only", 23, 32'h8);
    wr(20, 32'h100); wait_n(1);
    rd("R7 force hi", 18, 32'h100);
    chk("R7 forced fiq", {31'd0, fiq}, 32'd1);
    wr(20, 0); wr(21, 0); wait_n(1);
    chk("R7 cleared irq", {31'd0, irq}, 32'd0);
    chk("R7 cleared fiq", {31'd0, fiq}, 32'd0);
  endtask

  task automatic t_misc;
    rd("R10 constant word", 64, 32'd4);
    wr(2, 9);
    wr_byte(12'h200, 32'hFFFF_FFFF);
    wr_byte(12'h2FC, 32'hFFFF_FFFF);
    rd("R10 ignored range mask", 1, 32'h1F);
    rd("R10 ignored range enable", 5, 32'h208);
    rd("R10 undefined word", 32, 32'd0);
    rd("R10 word 16 undefined", 16, 32'd0);
  endtask

  task automatic t_ctrl;
    wr(0, 32'hFFFF_FFFF); rd("R11 ctrl filter", 0, 32'h7D);
    wr(0, 32'h2);         rd("R11 flag stays clear", 0, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_words();
    t_enable_num();
    t_prio();
    t_irq();
    t_fiq();
    t_force();
    t_misc();
    t_ctrl();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule